// File: doc/BRIEF.md
# Gated Reference Clock Output Divider

This block derives a slower clock for an external microcontroller from the crystal reference clock. It divides the reference by one of two even ratios, 4 or 8 by default. A single select bit chooses the ratio. The output stays low until the oscillator reports a stable amplitude, the configuration load is complete and software has enabled the output.

When all of these conditions hold, the output starts on a whole period that begins with a full-width high phase. Because no runt pulse can appear at switch-on, the microcontroller can use the first edge as a timing reference. A qualified ready indication rises on the same reference edge as that first rising edge of the output.

A change of ratio while the output is running is held back until the current output period ends. Power-down, a cleared enable, a lost ready flag or a missing configuration all stop the output on the next reference edge.

Top module: `refclk_out_gen`

## Requirements
- R1: While `rst` is high, and on the first reference edge after it is sampled high, `clk_out` and `ready_q` are 0.
- R2: With `div_sel` = 1 the output period is FAST_DIV (4) reference cycles: high for 2 cycles, then low for 2 cycles.
- R3: With `div_sel` = 0 the output period is SLOW_DIV (8) reference cycles: high for 4 cycles, then low for 4 cycles.
- R4: On the reference edge after `pwr_dn` = 1 or `clk_en` = 0 is sampled, `clk_out` and `ready_q` are 0.
- R5: No output clock appears and `ready_q` stays 0 while `osc_ready` is 0. `ready_q` is 1 only while `osc_ready`, `prog_done` and `clk_en` are all 1 and `pwr_dn` is 0.
- R6: If `prog_done` rises after `osc_ready`, the output stays low until the edge after `prog_done` is sampled high.
- R7: The first output period after activation is complete. The first sampled value is high, and it lasts the full half period.
- R8: A change of `div_sel` while running takes effect only at the next boundary of the output period.
- R9: `ready_q` goes high on the same reference edge as the first rising edge of `clk_out`.
- R10: When the enabling conditions are lost, `clk_out` and `ready_q` drop on the next reference edge. The next activation then starts a fresh full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down; 1 forces the output off |
| osc_ready | input | 1 | Oscillator amplitude-ready flag |
| prog_done | input | 1 | Configuration load complete |
| clk_en | input | 1 | Clock output enable bit |
| div_sel | input | 1 | Ratio select: 1 = FAST_DIV, 0 = SLOW_DIV |
| clk_out | output | 1 | Divided, gated clock output (registered) |
| ready_q | output | 1 | Qualified ready indication (registered) |

## Verification
The bench builds the block with its defaults, FAST_DIV = 4 and SLOW_DIV = 8. With these values both half periods (2 and 4 cycles) and a ratio switch at a period boundary fit inside a few reference cycles. Every phase position, including the wrap edge where a new ratio is latched, is therefore reached many times in a short run. Each gating input is dropped and restored at several phases, so the runt-free restart is seen from positions inside both the high and the low half of the output period.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

  typedef enum logic {
    RATIO_SLOW = 1'b0,
    RATIO_FAST = 1'b1
  } ratio_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refclk_qual.sv
module refclk_qual (
  input  logic pwr_dn,
  input  logic osc_ready,
  input  logic prog_done,
  input  logic clk_en,
  output logic run
);

  // All enabling conditions must hold at once; power-down overrides them.
  assign run = clk_en & osc_ready & prog_done & ~pwr_dn;

endmodule

// File: rtl/refclk_phase.sv
module refclk_phase
  import refclk_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  ratio_sel_e sel,
  output logic       out_clk,
  output logic       out_rdy
);

  localparam int MAXD = max2(FAST_DIV, SLOW_DIV);
  localparam int CW   = $clog2(MAXD) + 1;

  logic [CW-1:0] len_q;
  logic [CW-1:0] len_sel;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_nxt;
  logic [CW-1:0] half;
  logic          wrap;

  generate
    if (FAST_DIV == SLOW_DIV) begin : g_fixed
      assign len_sel = CW'(FAST_DIV);
    end else begin : g_select
      assign len_sel = (sel == RATIO_FAST) ? CW'(FAST_DIV) : CW'(SLOW_DIV);
    end
  endgenerate

  assign half    = len_q >> 1;
  assign pos_nxt = pos_q + CW'(1);
  assign wrap    = (pos_nxt == len_q);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      // Held idle: phase parked at zero so the next start is a full period.
      pos_q   <= '0;
      out_clk <= 1'b0;
      out_rdy <= 1'b0;
      len_q   <= len_sel;
    end else if (!out_rdy) begin
      // Activation edge: output and ready rise together on phase 0.
      pos_q   <= '0;
      out_clk <= 1'b1;
      out_rdy <= 1'b1;
      len_q   <= len_sel;
    end else if (wrap) begin
      // Period boundary: the only point where a new ratio is taken.
      pos_q   <= '0;
      out_clk <= 1'b1;
      len_q   <= len_sel;
    end else begin
      pos_q   <= pos_nxt;
      out_clk <= (pos_nxt < half);
    end
  end

endmodule

// File: rtl/refclk_out_gen.sv
module refclk_out_gen
  import refclk_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_dn,
  input  logic osc_ready,
  input  logic prog_done,
  input  logic clk_en,
  input  logic div_sel,
  output logic clk_out,
  output logic ready_q
);

  logic run;

  refclk_qual u_qual (
    .pwr_dn    (pwr_dn),
    .osc_ready (osc_ready),
    .prog_done (prog_done),
    .clk_en    (clk_en),
    .run       (run)
  );

  refclk_phase #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .sel     (ratio_sel_e'(div_sel)),
    .out_clk (clk_out),
    .out_rdy (ready_q)
  );

endmodule

// File: rtl/refclk_out_gen_chk.sv
module refclk_out_gen_chk (
  input logic clk,
  input logic rst,
  input logic pwr_dn,
  input logic osc_ready,
  input logic prog_done,
  input logic clk_en,
  input logic div_sel,
  input logic clk_out,
  input logic ready_q
);

  assert_off_when_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn || !clk_en) |=> (!clk_out && !ready_q));

  assert_wait_for_osc_R5: assert property (@(posedge clk) disable iff (rst)
    !osc_ready |=> !ready_q);

  assert_wait_for_prog_R6: assert property (@(posedge clk) disable iff (rst)
    !prog_done |=> !clk_out);

  assert_ready_with_first_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> clk_out);

  assert_no_runt_high_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_out) && ready_q) |=> (clk_out || !ready_q));

  assert_low_unless_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> !clk_out);

endmodule

bind refclk_out_gen refclk_out_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_dn    (pwr_dn),
  .osc_ready (osc_ready),
  .prog_done (prog_done),
  .clk_en    (clk_en),
  .div_sel   (div_sel),
  .clk_out   (clk_out),
  .ready_q   (ready_q)
);

// File: tb/refclk_out_gen_test.sv
module refclk_out_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic osc_ready = 1'b0;
  logic prog_done = 1'b0;
  logic clk_en = 1'b0;
  logic div_sel = 1'b1;
  logic clk_out;
  logic ready_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  refclk_out_gen uut (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn    (pwr_dn),
    .osc_ready (osc_ready),
    .prog_done (prog_done),
    .clk_en    (clk_en),
    .div_sel   (div_sel),
    .clk_out   (clk_out),
    .ready_q   (ready_q)
  );

  // Reference model built from the requirements: period length, phase, on flag.
  int m_len = 8;
  int m_pos = 0;
  bit m_on  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst || pwr_dn || !clk_en || !osc_ready || !prog_done) begin
      m_on  <= 1'b0;
      m_pos <= 0;
    end else if (!m_on) begin
      m_on  <= 1'b1;
      m_pos <= 0;
      m_len <= div_sel ? 4 : 8;
    end else if (m_pos == m_len - 1) begin
      m_pos <= 0;
      m_len <= div_sel ? 4 : 8;
    end else begin
      m_pos <= m_pos + 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic pd, input logic osc, input logic prg,
                        input logic en, input logic sel);
    pwr_dn = pd; osc_ready = osc; prog_done = prg; clk_en = en; div_sel = sel;
  endtask

  // Fields: pwr_dn, osc_ready, prog_done, clk_en, div_sel, cycles[7:0]
  localparam int NVEC = 12;
  localparam logic [12:0] VECS [NVEC] = '{
    {5'b01111, 8'd16},
    {5'b01110, 8'd24},
    {5'b01101, 8'd5},
    {5'b01111, 8'd9},
    {5'b11111, 8'd3},
    {5'b01111, 8'd7},
    {5'b00111, 8'd4},
    {5'b01110, 8'd11},
    {5'b01011, 8'd3},
    {5'b01111, 8'd6},
    {5'b01110, 8'd3},
    {5'b01111, 8'd13}
  };

  initial begin
    // R1: reset state
    set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) step();
    chk(clk_out, 1'b0, "R1", "clk_out in reset");
    chk(ready_q, 1'b0, "R1", "ready_q in reset");
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rst = 1'b0;
    step();

    // Table walk against the requirement model (R2, R3, R4, R5, R10)
    for (int v = 0; v < NVEC; v++) begin
      set_in(VECS[v][12], VECS[v][11], VECS[v][10], VECS[v][9], VECS[v][8]);
      for (int c = 0; c < int'(VECS[v][7:0]); c++) begin
        step();
        chk(clk_out, m_on && (m_pos < m_len / 2), VECS[v][8] ? "R2" : "R3", "table clk_out");
        chk(ready_q, m_on, "R5", "table ready_q");
      end
    end

    // Directed: idle, then fast ratio from a clean start (R2, R7, R9)
    set_in(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step();
    chk(clk_out, 1'b0, "R4", "disabled clk_out");
    set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step();
    chk(clk_out, 1'b1, "R7", "first sample high");
    chk(ready_q, 1'b1, "R9", "ready with first rise");
    for (int i = 1; i < 8; i++) begin
      step();
      chk(clk_out, (i % 4) < 2, "R2", "fast pattern");
    end

    // Directed: slow ratio, mid-period change waits for boundary (R8, R3)
    set_in(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step();
    set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step();
    chk(clk_out, 1'b1, "R8", "start fast");
    div_sel = 1'b0;
    step();
    chk(clk_out, 1'b1, "R8", "old ratio pos1");
    step();
    chk(clk_out, 1'b0, "R8", "old ratio pos2");
    step();
    chk(clk_out, 1'b0, "R8", "old ratio pos3");
    for (int i = 0; i < 16; i++) begin
      step();
      chk(clk_out, (i % 8) < 4, "R3", "slow pattern after boundary");
    end

    // Directed: late configuration (R6)
    set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(clk_out, 1'b0, "R6", "waiting for prog_done");
      chk(ready_q, 1'b0, "R6", "ready waiting for prog_done");
    end
    prog_done = 1'b1;
    step();
    chk(clk_out, 1'b1, "R6", "starts after prog_done");
    chk(ready_q, 1'b1, "R9", "ready after prog_done");
    step();
    chk(clk_out, 1'b1, "R7", "full high half");

    // Directed: oscillator not ready (R5)
    osc_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(ready_q, 1'b0, "R5", "osc not ready");
      chk(clk_out, 1'b0, "R5", "no clock without osc");
    end

    // Directed: power-down mid high phase (R10), then fresh start
    osc_ready = 1'b1;
    step();
    chk(clk_out, 1'b1, "R10", "restart high");
    pwr_dn = 1'b1;
    step();
    chk(clk_out, 1'b0, "R10", "drop on power-down");
    chk(ready_q, 1'b0, "R4", "ready drop on power-down");
    pwr_dn = 1'b0;
    step();
    chk(clk_out, 1'b1, "R10", "fresh period after power-down");
    step();
    chk(clk_out, 1'b1, "R7", "fresh period full high");

    // Directed: reset mid-run (R1)
    rst = 1'b1;
    step();
    chk(clk_out, 1'b0, "R1", "reset mid-run clk_out");
    chk(ready_q, 1'b0, "R1", "reset mid-run ready_q");
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule